// File: doc/BRIEF.md
# Row-Multiplexed DAC Word Sequencer

This block decides which 16-bit code each of 32 feedback DAC channels and 12 low-noise bias channels should carry, and when a downstream serializer should pick those codes up. A row-switch pulse, a frame-start pulse and the index of the row being visited drive it. Host-side registers supply a multiplex-enable mask, a table of values indexed by row and column, one constant per column, a stored value per bias line, two modulation-enable masks and a single shared modulation value. The host register protocol and the serial DAC interface are outside the block.

A column with multiplexing enabled is rewritten once per row visit from the table. A column without it changes only at frame start, so every such column moves together. A single load strobe fires a programmable number of cycles after each valid row switch. On the edge that ends the strobe, the multiplexed columns prefetch the following row's table entries, so the next strobe finds them ready. Bias lines change only at frame start. Their stored values can be read back and are zero after reset.

Top module: `rowmux_dac_seq`

## Requirements
- R1: While `rst_n` is low and after it rises, every word of `fb_words` and `ln_words` is 0, `dac_load` is 0, and every bias value returned on `bias_rd_data` is 0.
- R2: If a valid row switch is sampled at clock edge k with `load_dly` = D, then `dac_load` is high for exactly the one cycle between edges k+D and k+D+1. D = 0 therefore gives the strobe in the cycle right after the row switch.
- R3: A valid row switch that arrives while a strobe is still pending restarts the count from the new switch. It uses the `load_dly` value present at that switch, and the old count produces no strobe.
- R4: A row switch whose `row_idx` is N_ROWS or larger is ignored. It starts no count, does not change the remembered row, and leaves all output words unchanged.
- R5: On the edge that ends a strobe cycle, every column c whose `mux_en[c]` is 1 takes the table entry for row (r+1) mod N_ROWS and column c, where r is the last valid row index. The modulation term of R8 is added.
- R6: A column c whose `mux_en[c]` is 0 changes only on an edge with `frame_start` high. It then takes its constant register plus the modulation term of R8. A constant written in the middle of a frame does not appear before the next frame start.
- R7: A bias word in `ln_words` changes only on an edge with `frame_start` high. It then takes that line's stored bias value plus the modulation term of R8.
- R8: `mod_val` is added to feedback column c exactly when `fbmod_en[c]` is 1, and to bias line i exactly when `lnmod_en[i]` is 1, for any combination of bits. The sum wraps modulo 2^16 and does not saturate.
- R9: `bias_rd_data` returns, without a clock delay, the stored bias value of the line chosen by `bias_rd_sel`. It returns 0 for a selector of N_LN or larger. A write becomes visible one cycle after its edge.
- R10: Feedback column c occupies bits [16c+15:16c] of `fb_words`, and bias line i occupies bits [16i+15:16i] of `ln_words`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_switch | input | 1 | One-cycle pulse marking entry to a new row |
| frame_start | input | 1 | One-cycle pulse marking the start of a frame |
| row_idx | input | ROW_W | Index of the row being entered |
| mux_en | input | N_FB | Per-column multiplex enable |
| fbmod_en | input | N_FB | Per-column feedback modulation enable |
| lnmod_en | input | N_LN | Per-line bias modulation enable |
| mod_val | input | 16 | Shared modulation offset |
| load_dly | input | DLY_W | Cycles from row switch to strobe |
| tbl_we | input | 1 | Table write enable |
| tbl_row | input | ROW_W | Table write row |
| tbl_col | input | COL_W | Table write column |
| tbl_data | input | 16 | Table write data |
| cst_we | input | 1 | Constant write enable |
| cst_col | input | COL_W | Constant write column |
| cst_data | input | 16 | Constant write data |
| bias_we | input | 1 | Bias store write enable |
| bias_sel | input | LN_W | Bias store write line |
| bias_data | input | 16 | Bias store write data |
| bias_rd_sel | input | LN_W | Bias readback line select |
| bias_rd_data | output | 16 | Bias readback value |
| dac_load | output | 1 | Load strobe to the serializer |
| fb_words | output | 16*N_FB | Packed feedback words |
| ln_words | output | 16*N_LN | Packed bias words |

## Verification
On every cycle, the assertions check four things. A zero delay puts the strobe right after a valid switch. An out-of-range row never yields a strobe from an idle timer. Each strobe is preceded by a switch or a pending count. Bias words and non-strobe feedback words hold when no frame start or prefetch occurs. Only the bench scenarios can show which values land where: the row-ahead prefetch content, a mid-frame constant held back until the frame boundary, wrap-around of the modulation sum on chosen channels, the restart of a pending count, and readback contents. A per-cycle reference model covers all of these.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;
  localparam int WORD_W = 16;

  // Add the shared offset when the channel's enable is set; wraps modulo 2^16.
  function automatic logic [WORD_W-1:0] mod_word(input logic [WORD_W-1:0] base,
                                                 input logic en,
                                                 input logic [WORD_W-1:0] offs);
    mod_word = en ? (base + offs) : base;
  endfunction
endpackage

// File: rtl/dacseq_timer.sv
module dacseq_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  output logic             fire,
  output logic             busy
);
  logic [DLY_W-1:0] cnt_q;
  logic             fire_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (start) begin
        if (dly == '0) begin
          fire_q <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= dly;
        end
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == DLY_W'(1)) begin
          fire_q <= 1'b1;
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign fire = fire_q;
  assign busy = busy_q;
endmodule

// File: rtl/dacseq_row_table.sv
module dacseq_row_table #(
  parameter int N_ROWS = 8,
  parameter int N_FB   = 32,
  parameter int ROW_W  = 6,
  parameter int COL_W  = 5,
  localparam int RIX_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ROW_W-1:0]     wrow,
  input  logic [COL_W-1:0]     wcol,
  input  logic [15:0]          wdata,
  input  logic [RIX_W-1:0]     rd_row,
  output logic [16*N_FB-1:0]   rd_words
);
  localparam logic [ROW_W-1:0] ROW_LIMIT = ROW_W'(N_ROWS);
  localparam logic [COL_W:0]   COL_LIMIT = (COL_W+1)'(N_FB);

  logic [15:0] mem [N_ROWS][N_FB];

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    for (genvar c = 0; c < N_FB; c++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem[r][c] <= '0;
        end else if (we && (wrow == ROW_W'(r)) && ({1'b0, wcol} < COL_LIMIT)
                     && (wcol == COL_W'(c)) && (wrow < ROW_LIMIT)) begin
          mem[r][c] <= wdata;
        end
      end
    end
  end

  for (genvar c = 0; c < N_FB; c++) begin : g_rd
    assign rd_words[16*c +: 16] = mem[rd_row][c];
  end
endmodule

// File: rtl/dacseq_hold_bank.sv
module dacseq_hold_bank #(
  parameter int N     = 12,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [15:0]      wdata,
  output logic [16*N-1:0]  words
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[16*i +: 16] <= '0;
      end else if (we && (wsel == SEL_W'(i))) begin
        words[16*i +: 16] <= wdata;
      end
    end
  end
endmodule

// File: rtl/rowmux_dac_seq.sv
module rowmux_dac_seq #(
  parameter int N_FB   = 32,
  parameter int N_LN   = 12,
  parameter int N_ROWS = 8,
  parameter int ROW_W  = 6,
  parameter int DLY_W  = 8,
  localparam int COL_W = $clog2(N_FB),
  localparam int LN_W  = $clog2(N_LN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 row_switch,
  input  logic                 frame_start,
  input  logic [ROW_W-1:0]     row_idx,
  input  logic [N_FB-1:0]      mux_en,
  input  logic [N_FB-1:0]      fbmod_en,
  input  logic [N_LN-1:0]      lnmod_en,
  input  logic [15:0]          mod_val,
  input  logic [DLY_W-1:0]     load_dly,
  input  logic                 tbl_we,
  input  logic [ROW_W-1:0]     tbl_row,
  input  logic [COL_W-1:0]     tbl_col,
  input  logic [15:0]          tbl_data,
  input  logic                 cst_we,
  input  logic [COL_W-1:0]     cst_col,
  input  logic [15:0]          cst_data,
  input  logic                 bias_we,
  input  logic [LN_W-1:0]      bias_sel,
  input  logic [15:0]          bias_data,
  input  logic [LN_W-1:0]      bias_rd_sel,
  output logic [15:0]          bias_rd_data,
  output logic                 dac_load,
  output logic [16*N_FB-1:0]   fb_words,
  output logic [16*N_LN-1:0]   ln_words
);
  import dacseq_pkg::*;

  localparam int RIX_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1;
  localparam logic [ROW_W-1:0] ROW_LIMIT = ROW_W'(N_ROWS);
  localparam logic [RIX_W-1:0] LAST_ROW  = RIX_W'(N_ROWS - 1);
  localparam logic [LN_W:0]    LN_LIMIT  = (LN_W+1)'(N_LN);

  function automatic logic [RIX_W-1:0] row_after(input logic [RIX_W-1:0] r);
    row_after = (r == LAST_ROW) ? '0 : r + 1'b1;
  endfunction

  // Named internal events, also used by the bound checker.
  logic             row_ok;
  logic             tmr_busy;
  logic             pf_fire;
  logic [RIX_W-1:0] cur_row;
  logic [RIX_W-1:0] next_row;

  logic [16*N_FB-1:0] tbl_rd;
  logic [16*N_FB-1:0] cst_words;
  logic [16*N_LN-1:0] bias_store;
  logic [16*N_FB-1:0] fb_q;
  logic [16*N_LN-1:0] ln_q;

  assign row_ok   = row_switch && (row_idx < ROW_LIMIT);
  assign next_row = row_after(cur_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_row <= '0;
    else if (row_ok) cur_row <= row_idx[RIX_W-1:0];
  end

  dacseq_timer #(.DLY_W(DLY_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (row_ok),
    .dly   (load_dly),
    .fire  (pf_fire),
    .busy  (tmr_busy)
  );

  dacseq_row_table #(
    .N_ROWS (N_ROWS),
    .N_FB   (N_FB),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (tbl_we),
    .wrow     (tbl_row),
    .wcol     (tbl_col),
    .wdata    (tbl_data),
    .rd_row   (next_row),
    .rd_words (tbl_rd)
  );

  dacseq_hold_bank #(.N(N_FB), .SEL_W(COL_W)) u_consts (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cst_we),
    .wsel  (cst_col),
    .wdata (cst_data),
    .words (cst_words)
  );

  dacseq_hold_bank #(.N(N_LN), .SEL_W(LN_W)) u_bias (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bias_we),
    .wsel  (bias_sel),
    .wdata (bias_data),
    .words (bias_store)
  );

  // Feedback columns: multiplexed ones prefetch after a strobe,
  // the rest follow their constants at frame start.
  for (genvar c = 0; c < N_FB; c++) begin : g_fb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fb_q[16*c +: 16] <= '0;
      end else if (mux_en[c]) begin
        if (pf_fire)
          fb_q[16*c +: 16] <= mod_word(tbl_rd[16*c +: 16], fbmod_en[c], mod_val);
      end else if (frame_start) begin
        fb_q[16*c +: 16] <= mod_word(cst_words[16*c +: 16], fbmod_en[c], mod_val);
      end
    end
  end

  // Bias lines refresh only on frame boundaries.
  for (genvar i = 0; i < N_LN; i++) begin : g_ln
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ln_q[16*i +: 16] <= '0;
      else if (frame_start)
        ln_q[16*i +: 16] <= mod_word(bias_store[16*i +: 16], lnmod_en[i], mod_val);
    end
  end

  always_comb begin
    bias_rd_data = '0;
    for (int i = 0; i < N_LN; i++) begin
      if (({1'b0, bias_rd_sel} < LN_LIMIT) && (bias_rd_sel == LN_W'(i)))
        bias_rd_data = bias_store[16*i +: 16];
    end
  end

  assign dac_load = pf_fire;
  assign fb_words = fb_q;
  assign ln_words = ln_q;
endmodule

// File: rtl/dacseq_checker.sv
module dacseq_checker #(
  parameter int N_FB  = 32,
  parameter int N_LN  = 12,
  parameter int DLY_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               row_switch,
  input logic               frame_start,
  input logic [DLY_W-1:0]   load_dly,
  input logic               dac_load,
  input logic [16*N_FB-1:0] fb_words,
  input logic [16*N_LN-1:0] ln_words,
  input logic               row_ok,
  input logic               tmr_busy,
  input logic               pf_fire
);
  AST_ZERO_DLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (row_ok && load_dly == '0) |=> dac_load); // R2

  AST_LOAD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_load) |-> $past(row_ok || tmr_busy)); // R2

  AST_BAD_ROW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (row_switch && !row_ok && !tmr_busy) |=> !dac_load); // R4

  AST_LN_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(ln_words)); // R7

  AST_FB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !pf_fire) |=> $stable(fb_words)); // R6
endmodule

bind rowmux_dac_seq dacseq_checker #(
  .N_FB  (N_FB),
  .N_LN  (N_LN),
  .DLY_W (DLY_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .row_switch  (row_switch),
  .frame_start (frame_start),
  .load_dly    (load_dly),
  .dac_load    (dac_load),
  .fb_words    (fb_words),
  .ln_words    (ln_words),
  .row_ok      (row_ok),
  .tmr_busy    (tmr_busy),
  .pf_fire     (pf_fire)
);

// File: tb/sim_rowmux_dac_seq.sv
`timescale 1ns/1ps
module sim_rowmux_dac_seq;
  localparam int NF = 32, NL = 12, NR = 8, RW = 6, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic row_switch = 0, frame_start = 0;
  logic [RW-1:0] row_idx = '0;
  logic [NF-1:0] mux_en = '0, fbmod_en = '0;
  logic [NL-1:0] lnmod_en = '0;
  logic [15:0] mod_val = '0;
  logic [DW-1:0] load_dly = '0;
  logic tbl_we = 0; logic [RW-1:0] tbl_row = '0; logic [4:0] tbl_col = '0; logic [15:0] tbl_data = '0;
  logic cst_we = 0; logic [4:0] cst_col = '0; logic [15:0] cst_data = '0;
  logic bias_we = 0; logic [3:0] bias_sel = '0; logic [15:0] bias_data = '0;
  logic [3:0] bias_rd_sel = '0;
  logic [15:0] bias_rd_data;
  logic dac_load;
  logic [16*NF-1:0] fb_words;
  logic [16*NL-1:0] ln_words;

  rowmux_dac_seq #(.N_FB(NF), .N_LN(NL), .N_ROWS(NR), .ROW_W(RW), .DLY_W(DW)) u0 (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  // ---------------- reference model ----------------
  logic [15:0] m_tbl [NR][NF];
  logic [15:0] m_cst [NF];
  logic [15:0] m_bias [NL];
  logic [15:0] m_fb [NF];
  logic [15:0] m_ln [NL];
  bit m_load, m_pend;
  int m_cnt, m_row;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_load = 0; m_pend = 0; m_cnt = 0; m_row = 0;
      for (int r = 0; r < NR; r++) for (int c = 0; c < NF; c++) m_tbl[r][c] = 0;
      for (int c = 0; c < NF; c++) begin m_cst[c] = 0; m_fb[c] = 0; end
      for (int i = 0; i < NL; i++) begin m_bias[i] = 0; m_ln[i] = 0; end
    end else begin
      bit was_load;
      int nx;
      was_load = m_load;
      nx = (m_row + 1) % NR;
      for (int c = 0; c < NF; c++) begin
        if (mux_en[c] && was_load) m_fb[c] = m_tbl[nx][c] + (fbmod_en[c] ? mod_val : 16'd0);
        else if (!mux_en[c] && frame_start) m_fb[c] = m_cst[c] + (fbmod_en[c] ? mod_val : 16'd0);
      end
      if (frame_start)
        for (int i = 0; i < NL; i++) m_ln[i] = m_bias[i] + (lnmod_en[i] ? mod_val : 16'd0);
      m_load = 0;
      if (row_switch && int'(row_idx) < NR) begin
        m_row = int'(row_idx);
        if (load_dly == 0) begin m_load = 1; m_pend = 0; end
        else begin m_pend = 1; m_cnt = int'(load_dly); end
      end else if (m_pend) begin
        m_cnt--;
        if (m_cnt == 0) begin m_load = 1; m_pend = 0; end
      end
      if (tbl_we && int'(tbl_row) < NR) m_tbl[tbl_row][tbl_col] = tbl_data;
      if (cst_we) m_cst[cst_col] = cst_data;
      if (bias_we && int'(bias_sel) < NL) m_bias[bias_sel] = bias_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fbw(input int c); return fb_words[16*c +: 16]; endfunction
  function automatic logic [15:0] lnw(input int i); return ln_words[16*i +: 16]; endfunction

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int bad_c, bad_i;
      logic [15:0] exp_rd;
      bad_c = -1; bad_i = -1;
      for (int c = 0; c < NF; c++) if (bad_c < 0 && fbw(c) !== m_fb[c]) bad_c = c;
      for (int i = 0; i < NL; i++) if (bad_i < 0 && lnw(i) !== m_ln[i]) bad_i = i;
      exp_rd = (int'(bias_rd_sel) < NL) ? m_bias[bias_rd_sel] : 16'd0;
      chk(dac_load === m_load, "R2 strobe", int'(dac_load), int'(m_load));
      if (bad_c >= 0) chk(0, "R5/R6 fb word", fbw(bad_c), m_fb[bad_c]); else chk(1, "R5", 0, 0);
      if (bad_i >= 0) chk(0, "R7 ln word", lnw(bad_i), m_ln[bad_i]); else chk(1, "R7", 0, 0);
      chk(bias_rd_data === exp_rd, "R9 readback", bias_rd_data, exp_rd);
    end
  end

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n); repeat (n) @(negedge clk); endtask

  task automatic pulse_row(input int r);
    @(negedge clk); row_switch = 1; row_idx = RW'(r);
    @(negedge clk); row_switch = 0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  // Measure negedges from the end of a row pulse to the strobe.
  task automatic wait_load(output int n);
    n = 0;
    while (!dac_load && n < 300) begin @(negedge clk); n++; end
  endtask

  function automatic logic [15:0] tv(input int r, input int c); return 16'h1000 + 16'(r*64 + c); endfunction

  initial begin
    int n;
    logic [16*NF-1:0] snap_fb;
    step(3);
    // R1: reset state
    chk(fb_words === '0, "R1 fb reset", int'(fb_words[31:0]), 0);
    chk(ln_words === '0, "R1 ln reset", int'(ln_words[31:0]), 0);
    chk(dac_load === 1'b0, "R1 load reset", int'(dac_load), 0);
    chk(bias_rd_data === 16'd0, "R1 readback reset", bias_rd_data, 0);
    rst_n = 1;
    step(2);
    chk(fb_words === '0 && dac_load === 1'b0, "R1 after release", int'(fb_words[15:0]), 0);

    // program table, constants, bias store
    for (int r = 0; r < NR; r++) for (int c = 0; c < NF; c++) begin
      @(negedge clk); tbl_we = 1; tbl_row = RW'(r); tbl_col = 5'(c); tbl_data = tv(r, c);
    end
    @(negedge clk); tbl_we = 0;
    for (int c = 0; c < NF; c++) begin
      @(negedge clk); cst_we = 1; cst_col = 5'(c); cst_data = 16'hC000 + 16'(c);
    end
    @(negedge clk); cst_we = 0;
    for (int i = 0; i < NL; i++) begin
      @(negedge clk); bias_we = 1; bias_sel = 4'(i); bias_data = 16'h5000 + 16'(i);
    end
    @(negedge clk); bias_we = 0;
    bias_rd_sel = 4'd5; step(1);
    chk(bias_rd_data === 16'h5005, "R9 readback line 5", bias_rd_data, 16'h5005);
    bias_rd_sel = 4'd13; step(1);
    chk(bias_rd_data === 16'h0000, "R9 out-of-range select", bias_rd_data, 0);
    chk(lnw(5) === 16'h0000, "R7 no frame yet", lnw(5), 0);

    mux_en = 32'hFFFF_FF0F; load_dly = 8'd3;
    pulse_frame();
    chk(fbw(4) === 16'hC004, "R6 frame const col4", fbw(4), 16'hC004);
    chk(lnw(2) === 16'h5002, "R7 frame bias line2", lnw(2), 16'h5002);
    chk(fbw(0) === 16'h0000, "R5 no prefetch yet", fbw(0), 0);

    // Row cycling with delay 3
    for (int s = 0; s < 10; s++) begin
      pulse_row(s % NR);
      wait_load(n);
      chk(n == 3, "R2 delay 3", n, 3);
      step(1);
      chk(fbw(0) === tv((s + 1) % NR, 0), "R5 prefetch col0", fbw(0), tv((s + 1) % NR, 0));
      chk(fbw(31) === tv((s + 1) % NR, 31), "R10 packing col31", fbw(31), tv((s + 1) % NR, 31));
      step(6);
    end

    // R6: mid-frame constant write held until frame start
    @(negedge clk); cst_we = 1; cst_col = 5'd4; cst_data = 16'hABCD;
    @(negedge clk); cst_we = 0;
    pulse_row(2); step(8);
    chk(fbw(4) === 16'hC004, "R6 held mid-frame", fbw(4), 16'hC004);
    // R7 / R9: mid-frame bias write
    @(negedge clk); bias_we = 1; bias_sel = 4'd3; bias_data = 16'h7777; bias_rd_sel = 4'd3;
    @(negedge clk); bias_we = 0;
    chk(bias_rd_data === 16'h7777, "R9 readback after write", bias_rd_data, 16'h7777);
    chk(lnw(3) === 16'h5003, "R7 held mid-frame", lnw(3), 16'h5003);
    pulse_frame();
    chk(fbw(4) === 16'hABCD, "R6 applied at frame", fbw(4), 16'hABCD);
    chk(lnw(3) === 16'h7777, "R7 applied at frame", lnw(3), 16'h7777);

    // R8: modulation on scattered channels, wrapping sum
    mod_val = 16'hF000; fbmod_en = 32'h8000_0010; lnmod_en = 12'h808;
    pulse_frame();
    chk(fbw(4) === 16'h9BCD, "R8 wrap col4", fbw(4), 16'h9BCD);
    chk(fbw(5) === 16'hC005, "R8 col5 untouched", fbw(5), 16'hC005);
    chk(lnw(3) === 16'h6777, "R8 wrap bias3", lnw(3), 16'h6777);
    chk(lnw(11) === 16'h400B, "R8 wrap bias11", lnw(11), 16'h400B);
    chk(lnw(0) === 16'h5000, "R8 bias0 untouched", lnw(0), 16'h5000);
    pulse_row(5); wait_load(n); step(1);
    chk(fbw(31) === tv(6, 31) + 16'hF000, "R8 mux col31", fbw(31), tv(6, 31) + 16'hF000);
    chk(fbw(30) === tv(6, 30), "R8 mux col30 untouched", fbw(30), tv(6, 30));

    // R2: zero delay
    load_dly = 8'd0; step(4);
    pulse_row(6); wait_load(n);
    chk(n == 0, "R2 delay 0", n, 0);
    step(4);

    // R3: restart while pending
    load_dly = 8'd5;
    pulse_row(1); step(1);
    pulse_row(2); wait_load(n);
    chk(n == 5, "R3 restart count", n, 5);
    step(1);
    chk(fbw(0) === tv(3, 0), "R3 prefetch follows newer row", fbw(0), tv(3, 0));
    step(10);

    // R4: out-of-range row ignored
    snap_fb = fb_words;
    pulse_row(40);
    n = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); if (dac_load) n++; end
    chk(n == 0, "R4 no strobe", n, 0);
    chk(fb_words === snap_fb, "R4 words held", int'(fb_words[15:0]), int'(snap_fb[15:0]));
    pulse_row(3); wait_load(n); step(1);
    chk(fbw(0) === tv(4, 0), "R4 row memory kept", fbw(0), tv(4, 0));
    step(5);

    summary();
  end
endmodule